// File: doc/BRIEF.md
# UART Receive FIFO with Line Status

This block sits behind the bit-level receiver of a UART. Each time the shift register finishes a character, it offers the byte here together with a flag that says whether the parity check failed. The block queues the character in a 16-entry FIFO. It shows the oldest unread character on its output, and it keeps a small read-only status word with three bits: data-ready, overrun and parity-error.

Each FIFO entry carries its own parity tag. The parity-error bit therefore describes the character that software is about to read, and not the one most recently received. When a character arrives while the FIFO is full, it is discarded and the queued data stays intact. The overrun and parity-error bits stay set until the status word is read. A status read in the same cycle as a new error event leaves the bit set, so the event is not lost.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset, `stat_ready`, `stat_overrun` and `stat_parity` are 0, and `head_data` is 0.
- R2: `stat_ready` is 1 exactly when the FIFO holds at least one unread character. It rises on the clock edge that stores a character into an empty FIFO and falls on the edge that removes the last one.
- R3: Characters leave in arrival order. `head_data` shows the oldest unread character and shows 0 while the FIFO is empty. A `data_rd` pulse removes the head on the next edge.
- R4: `stat_overrun` is set on the edge after `char_valid` is seen while the FIFO holds 16 characters. This applies even when `data_rd` is high in the same cycle.
- R5: A character that causes an overrun is dropped, and the 16 queued characters and their order are unchanged.
- R6: A `status_rd` pulse clears `stat_overrun` on the next edge, unless a new overrun happens in that same cycle, in which case the bit stays 1.
- R7: A `status_rd` pulse clears `stat_parity` on the next edge, unless a parity-tagged character becomes the head in that same cycle, in which case the bit stays 1.
- R8: `stat_parity` is set on the same edge that a character received with `char_perr`=1 becomes the head, whether it is pushed into an empty FIFO or reached by a read. A tagged character that is queued behind the head does not set it.
- R9: `data_rd` while the FIFO is empty is ignored. The FIFO stays empty and status bits are unaffected.
- R10: The FIFO holds exactly 16 characters. The 16th character is accepted without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Shift register offers a completed character |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity check failed for this character |
| data_rd | input | 1 | Consume the head character |
| status_rd | input | 1 | Status word is read (clears sticky bits) |
| head_data | output | 8 | Oldest unread character, 0 when empty |
| stat_ready | output | 1 | At least one unread character |
| stat_overrun | output | 1 | Sticky overrun flag |
| stat_parity | output | 1 | Sticky parity flag for the head character |

## Verification
The bench drives a tagged character into the second slot and checks that the parity bit stays low until that character becomes the head. A design that flagged the newest character would raise it too early. The bench fills the FIFO to exactly 16 entries, then sends more characters, with and without a same-cycle read. A design that overwrote or popped on overflow would show a changed head or a lost order when the FIFO drains. It also issues status reads that collide with a new overrun or a tagged head arrival, and data reads on an empty FIFO. These expose a clear that wins over a set, and a read that corrupts the count or the pointers. Long pseudo-random traffic is compared against a queue model on every cycle.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

   // Where the next head entry comes from on a clock edge
   typedef enum logic [1:0] {
      ARR_NONE     = 2'd0,
      ARR_INCOMING = 2'd1,
      ARR_QUEUED   = 2'd2
   } arrival_src_e;

   function automatic int unsigned fill_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/rxf_storage.sv
module rxf_storage
   import uart_rxf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = ptr_width(DEPTH),
   localparam int unsigned CNT_W = fill_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_tag,
   output logic [DATA_W-1:0] head_data,
   output logic              next_tag,
   output logic [CNT_W-1:0]  count
);

   localparam int unsigned ENT_W = DATA_W + 1;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic [PTR_W-1:0] rd_inc, wr_inc;
   logic [ENT_W-1:0] head_ent, next_ent;

   generate
      if (POW2) begin : g_wrap_free
         assign rd_inc = rd_ptr + 1'b1;
         assign wr_inc = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= {wr_tag, wr_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_inc;
         if (pop)  rd_ptr <= rd_inc;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_ent  = mem[rd_ptr];
   assign next_ent  = mem[rd_inc];
   assign head_data = head_ent[DATA_W-1:0];
   assign next_tag  = next_ent[DATA_W];

endmodule

// File: rtl/rxf_status.sv
module rxf_status
   import uart_rxf_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         status_rd,
   input  logic         ovr_event,
   input  arrival_src_e arr_src,
   input  logic         incoming_tag,
   input  logic         queued_tag,
   output logic         overrun,
   output logic         parity
);

   logic arr_tag;

   always_comb begin
      unique case (arr_src)
         ARR_INCOMING: arr_tag = incoming_tag;
         ARR_QUEUED:   arr_tag = queued_tag;
         default:      arr_tag = 1'b0;
      endcase
   end

   // A set in the clearing cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
         parity  <= 1'b0;
      end else begin
         overrun <= (overrun & ~status_rd) | ovr_event;
         parity  <= (parity  & ~status_rd) | arr_tag;
      end
   end

endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
   import uart_rxf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_valid,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_perr,
   input  logic              data_rd,
   input  logic              status_rd,
   output logic [DATA_W-1:0] head_data,
   output logic              stat_ready,
   output logic              stat_overrun,
   output logic              stat_parity
);

   localparam int unsigned CNT_W = fill_width(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_rx_fifo_status: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_rx_fifo_status: DATA_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  fill_cnt;
   logic [DATA_W-1:0] raw_head;
   logic              nxt_tag;
   logic              is_empty, is_full;
   logic              push, pop, ovr_event;
   arrival_src_e      arr_src;

   assign is_empty  = (fill_cnt == '0);
   assign is_full   = (fill_cnt == CNT_W'(DEPTH));
   assign push      = char_valid & ~is_full;
   assign pop       = data_rd & ~is_empty;
   assign ovr_event = char_valid & is_full;

   always_comb begin
      if (pop && fill_cnt >= CNT_W'(2))
         arr_src = ARR_QUEUED;
      else if (push && (is_empty || (pop && fill_cnt == CNT_W'(1))))
         arr_src = ARR_INCOMING;
      else
         arr_src = ARR_NONE;
   end

   rxf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .wr_data   (char_data),
      .wr_tag    (char_perr),
      .head_data (raw_head),
      .next_tag  (nxt_tag),
      .count     (fill_cnt)
   );

   rxf_status u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .status_rd    (status_rd),
      .ovr_event    (ovr_event),
      .arr_src      (arr_src),
      .incoming_tag (char_perr),
      .queued_tag   (nxt_tag),
      .overrun      (stat_overrun),
      .parity       (stat_parity)
   );

   assign stat_ready = ~is_empty;
   assign head_data  = is_empty ? '0 : raw_head;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
   import uart_rxf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = fill_width(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_valid,
   input logic              data_rd,
   input logic              status_rd,
   input logic [DATA_W-1:0] head_data,
   input logic              stat_ready,
   input logic              stat_overrun,
   input logic              stat_parity,
   input logic [CNT_W-1:0]  fill_cnt
);

   logic full;
   assign full = (fill_cnt == CNT_W'(DEPTH));

   // R2: a character offered to an empty FIFO is always stored
   assert_ready_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !stat_ready) |=> stat_ready);

   // R4: incoming character on a full FIFO flags overrun
   assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && full) |=> stat_overrun);

   // R5: dropped character leaves the head untouched
   assert_keep_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && full && !data_rd) |=> ($stable(head_data) && stat_ready));

   // R6: status read clears overrun when no new overrun collides
   assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !(char_valid && full)) |=> !stat_overrun);

   // R7: status read clears parity when the head does not change
   assert_parity_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !char_valid && !data_rd) |=> !stat_parity);

   // R9: read of an empty FIFO leaves it empty
   assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_ready && data_rd && !char_valid) |=> !stat_ready);

   // R10: fill level never exceeds the capacity
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(DEPTH));

endmodule

bind uart_rx_fifo_status rxf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .char_valid   (char_valid),
   .data_rd      (data_rd),
   .status_rd    (status_rd),
   .head_data    (head_data),
   .stat_ready   (stat_ready),
   .stat_overrun (stat_overrun),
   .stat_parity  (stat_parity),
   .fill_cnt     (fill_cnt)
);

// File: tb/uart_rx_fifo_status_test.sv
module uart_rx_fifo_status_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_valid = 1'b0;
   logic [7:0] char_data = '0;
   logic       char_perr = 1'b0;
   logic       data_rd = 1'b0;
   logic       status_rd = 1'b0;
   logic [7:0] head_data;
   logic       stat_ready, stat_overrun, stat_parity;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [8:0] q[$];
   bit m_ovr = 0;
   bit m_par = 0;

   always #10 clk = ~clk;

   uart_rx_fifo_status uut (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .char_perr(char_perr), .data_rd(data_rd), .status_rd(status_rd),
      .head_data(head_data), .stat_ready(stat_ready),
      .stat_overrun(stat_overrun), .stat_parity(stat_parity)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare(input string req);
      int exp_head;
      exp_head = (q.size() != 0) ? int'(q[0][7:0]) : 0;
      chk(req, "head_data", int'(head_data), exp_head);
      chk(req, "stat_ready", int'(stat_ready), int'(q.size() != 0));
      chk(req, "stat_overrun", int'(stat_overrun), int'(m_ovr));
      chk(req, "stat_parity", int'(stat_parity), int'(m_par));
   endtask

   // one cycle: drive after negedge, model the edge, compare at next negedge
   task automatic step(input bit cv, input logic [7:0] cd, input bit cp,
                       input bit dr, input bit sr, input string req);
      int  n;
      bit  push, pop, arr;
      char_valid = cv; char_data = cd; char_perr = cp;
      data_rd = dr; status_rd = sr;
      @(posedge clk);
      n    = q.size();
      push = cv && (n < 16);
      pop  = dr && (n != 0);
      arr  = 0;
      if (pop && n >= 2) arr = q[1][8];
      else if (push && (n == 0 || (pop && n == 1))) arr = cp;
      m_par = (m_par && !sr) || arr;
      m_ovr = (m_ovr && !sr) || (cv && n == 16);
      if (pop)  void'(q.pop_front());
      if (push) q.push_back({cp, cd});
      @(negedge clk);
      char_valid = 0; data_rd = 0; status_rd = 0; char_perr = 0;
      compare(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R9: read while empty
      step(0, 8'h00, 0, 1, 0, "R9");
      chk("R9", "ready after empty read", int'(stat_ready), 0);

      // R8: tagged character queued behind the head must not flag parity
      step(1, 8'h11, 0, 0, 0, "R2");
      step(1, 8'h22, 1, 0, 0, "R8");
      chk("R8", "parity with tag behind head", int'(stat_parity), 0);
      step(1, 8'h33, 0, 0, 0, "R8");
      step(0, 8'h00, 0, 1, 0, "R8");
      chk("R8", "parity when tagged reaches head", int'(stat_parity), 1);
      chk("R3", "head order", int'(head_data), 'h22);
      step(0, 8'h00, 0, 0, 1, "R7");
      chk("R7", "parity cleared by status read", int'(stat_parity), 0);
      step(0, 8'h00, 0, 1, 0, "R3");
      step(0, 8'h00, 0, 1, 0, "R2");
      chk("R2", "ready after last pop", int'(stat_ready), 0);

      // R8: tagged push into empty FIFO, plus simultaneous status read (R7)
      step(1, 8'h44, 1, 0, 1, "R7");
      chk("R7", "tagged arrival wins over clear", int'(stat_parity), 1);
      step(0, 8'h00, 0, 1, 1, "R7");

      // R10/R5: fill to 16 then overflow
      for (int i = 0; i < 16; i++) step(1, 8'(8'h80 + i), 0, 0, 0, "R10");
      chk("R10", "overrun after 16", int'(stat_overrun), 0);
      step(1, 8'hEE, 1, 0, 0, "R4");
      chk("R4", "overrun set", int'(stat_overrun), 1);
      chk("R5", "head kept", int'(head_data), 'h80);
      step(1, 8'hEF, 0, 1, 0, "R4");
      step(0, 8'h00, 0, 0, 1, "R6");
      chk("R6", "overrun cleared", int'(stat_overrun), 0);
      step(1, 8'hF0, 0, 0, 0, "R5");
      step(1, 8'hF1, 0, 0, 1, "R6");
      chk("R6", "new overrun wins over clear", int'(stat_overrun), 1);
      step(0, 8'h00, 0, 0, 1, "R6");
      while (q.size() != 0) step(0, 8'h00, 0, 1, 0, "R5");
      step(0, 8'h00, 0, 1, 0, "R9");

      // mixed traffic against the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[1], lfsr[15:8], lfsr[2] & lfsr[3],
              lfsr[4] & (lfsr[5] | (k > 1500)), lfsr[6] & lfsr[7] & lfsr[9], "R3");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule